// File: doc/BRIEF.md
# Memory ECC Syndrome Decoder with Error Capture Register

This block sits beside a memory controller's error-correction logic. Each access that reports an error event presents a 7-bit syndrome, the failing address and three side flags: uncorrectable, refresh error and parity error. The decoder classifies the syndrome in the same cycle. A correctable single-bit failure is reported with the position of the failing data bit or check bit. Anything else that is non-zero is reported as uncorrectable.

The same event also updates a 36-bit status word that software reads back. The word holds a frozen record of the first error it captured: the syndrome, the address, the held flag and the uncorrectable flag. It also holds sticky refresh and backup-power flags that software clears by writing a 1, a parity flag that software can read and write, and the ECC-enabled indication. The write port also drives the diagnostic controls, which are a 7-bit forced check-bit pattern and an ECC-disable bit.

Top module: `ecc_err_capture`

## Requirements
- R1: A syndrome of zero means no error: correctable_o, uncorrectable_o and fail_in_check_o are 0, fail_pos_o is 0, and nothing is captured.
- R2: With syndrome bit 6 set, a lower-6 value (bits 5:0) equal to octal 01, 02, 04, 10, 20 or 40 marks check bit 0, 1, 2, 3, 4 or 5 as failed. A lower-6 value of 0 with bit 6 set marks check bit 6. In both cases correctable_o=1, fail_in_check_o=1, and fail_pos_o gives the check-bit index.
- R3: With bit 6 set, a lower-6 value whose upper octal digit r and lower octal digit c both lie in 1..6 marks data bit 42-6r-c as failed (octal 11 gives bit 35, octal 66 gives bit 0). The result is correctable_o=1 and fail_in_check_o=0.
- R4: A non-zero syndrome that is not covered by R2 or R3 gives uncorrectable_o=1; this includes any syndrome with bit 6 clear. Status bit 34 captures the value evt_uncorr_i OR that classification, and software writes never change it.
- R5: An event with evt_valid_i=1 and either a non-zero syndrome or evt_uncorr_i=1, taken while no record is held, is captured on that clock edge. The capture sets status bit 35, loads the syndrome into bits 30:24 and loads the address into bits 21:0.
- R6: While bit 35 is set, later events leave bits 34, 30:24 and 21:0 unchanged.
- R7: Writing 1 to bit 35 clears it; writing 0 there has no effect. If that clearing write arrives in the same cycle as a capturable event, the event is captured and bit 35 stays set.
- R8: Bit 33 is set by an event that carries evt_refresh_i, and bit 23 is set whenever pwr_low_i is high. Both flags stay set until a write puts 1 in their own bit position. When a set and a clear arrive together, the set wins.
- R9: Bit 32 is loaded from wr_data_i[32] on every write, and any event that carries evt_parity_i sets it. The event wins over a simultaneous write.
- R10: Every write loads force_chk_o from wr_data_i[7:1] and ecc_dis_o from wr_data_i[0]. force_en_o is 1 exactly when force_chk_o is non-zero, and status bit 31 reads as the inverse of ecc_dis_o.
- R11: After reset the status word reads with only bit 31 set, and force_chk_o, force_en_o and ecc_dis_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Access error event present |
| evt_syn_i | input | 7 | ECC syndrome of the access |
| evt_addr_i | input | 22 | Address of the access |
| evt_uncorr_i | input | 1 | Uncorrectable error reported by memory |
| evt_refresh_i | input | 1 | Refresh error |
| evt_parity_i | input | 1 | Parity error |
| pwr_low_i | input | 1 | Backup power low level |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 36 | Status register write data |
| fail_pos_o | output | 6 | Index of the failing data or check bit |
| fail_in_check_o | output | 1 | Failing bit is a check bit |
| correctable_o | output | 1 | Syndrome decodes to a single-bit error |
| uncorrectable_o | output | 1 | Syndrome non-zero and not correctable |
| stat_o | output | 36 | Status word readback |
| force_chk_o | output | 7 | Forced check-bit pattern |
| force_en_o | output | 1 | Forced check bits in effect |
| ecc_dis_o | output | 1 | ECC disabled |

## Verification
The assertions check several rules on every cycle. The two classifications are never both asserted, and a check-bit report only ever comes with a correctable result. A held record never moves or drops until a clearing write. A free capture, a refresh event and a write each reach the status word and the controls one edge later. Only the bench's scenarios show the exact bit-position map for each syndrome row and the rejection of unmapped codes. The same holds for the same-cycle clear-and-capture case and for the set-wins priority of the sticky flags against writes.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int unsigned SYN_W   = 7;
  localparam int unsigned CHK_W   = SYN_W - 1;
  localparam int unsigned DIG_W   = CHK_W / 2;
  localparam int unsigned DIGITS  = 6;
  localparam int unsigned DATA_W  = 36;
  localparam int unsigned POS_W   = 6;
  localparam int unsigned STAT_W  = 36;

  // status word field positions (software decodes these)
  localparam int unsigned B_HELD  = 35;
  localparam int unsigned B_UNC   = 34;
  localparam int unsigned B_REFR  = 33;
  localparam int unsigned B_PAR   = 32;
  localparam int unsigned B_ENA   = 31;
  localparam int unsigned B_SYNLO = 24;
  localparam int unsigned B_PWR   = 23;
  localparam int unsigned B_FRCLO = 1;
  localparam int unsigned B_DIS   = 0;

  typedef struct packed {
    logic             corr;
    logic             uncorr;
    logic             in_chk;
    logic [POS_W-1:0] pos;
  } dec_res_t;
endpackage

// File: rtl/ecc_synd_dec.sv
module ecc_synd_dec
  import ecc_cap_pkg::*;
(
  input  logic             vld_i,
  input  logic [SYN_W-1:0] syn_i,
  output dec_res_t         res_o
);
  logic [CHK_W-1:0] low;
  logic             top;
  logic [DIG_W-1:0] row, col;
  logic             chk_hit, dat_hit;
  logic [POS_W-1:0] chk_pos, dat_pos;

  assign low = syn_i[CHK_W-1:0];
  assign top = syn_i[SYN_W-1];
  assign row = low[CHK_W-1:DIG_W];
  assign col = low[DIG_W-1:0];

  // check-bit code: one-hot lower field, or empty lower field = parity bit
  always_comb begin
    chk_hit = $onehot0(low);
    chk_pos = POS_W'(CHK_W);
    for (int i = 0; i < int'(CHK_W); i++) begin
      if (low[i]) chk_pos = POS_W'(i);
    end
  end

  // data code: both octal digits in 1..DIGITS, rows of DIGITS from the top bit
  always_comb begin
    int p;
    dat_hit = (row != '0) && (int'(row) <= int'(DIGITS)) &&
              (col != '0) && (int'(col) <= int'(DIGITS));
    p       = int'(DATA_W) + int'(DIGITS) - int'(DIGITS) * int'(row) - int'(col);
    dat_pos = dat_hit ? POS_W'(p) : '0;
  end

  always_comb begin
    res_o        = '0;
    res_o.corr   = vld_i && top && (chk_hit || dat_hit);
    res_o.uncorr = vld_i && (syn_i != '0) && !res_o.corr;
    res_o.in_chk = res_o.corr && !dat_hit;
    if (res_o.corr) res_o.pos = dat_hit ? dat_pos : chk_pos;
  end
endmodule

// File: rtl/ecc_stat_reg.sv
module ecc_stat_reg
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [SYN_W-1:0]  cap_syn_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic              cap_unc_i,
  input  logic              refr_set_i,
  input  logic              par_set_i,
  input  logic              pwr_set_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [CHK_W:0]    force_chk_o,
  output logic              ecc_dis_o
);
  logic              held_q, unc_q, refr_q, par_q, pwr_q, dis_q;
  logic [CHK_W:0]    frc_q;
  logic [SYN_W-1:0]  syn_q;
  logic [ADDR_W-1:0] addr_q;
  logic              clr_held, take;

  assign clr_held = wr_en_i && wr_data_i[B_HELD];
  assign take     = cap_i && (!held_q || clr_held);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      unc_q  <= 1'b0;
      syn_q  <= '0;
      addr_q <= '0;
    end else if (take) begin
      held_q <= 1'b1;
      unc_q  <= cap_unc_i;
      syn_q  <= cap_syn_i;
      addr_q <= cap_addr_i;
    end else if (clr_held) begin
      held_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refr_q <= 1'b0;
      pwr_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      if (refr_set_i)                       refr_q <= 1'b1;
      else if (wr_en_i && wr_data_i[B_REFR]) refr_q <= 1'b0;
      if (pwr_set_i)                        pwr_q  <= 1'b1;
      else if (wr_en_i && wr_data_i[B_PWR])  pwr_q  <= 1'b0;
      if (par_set_i)                        par_q  <= 1'b1;
      else if (wr_en_i)                     par_q  <= wr_data_i[B_PAR];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frc_q <= '0;
      dis_q <= 1'b0;
    end else if (wr_en_i) begin
      frc_q <= wr_data_i[B_FRCLO +: CHK_W+1];
      dis_q <= wr_data_i[B_DIS];
    end
  end

  always_comb begin
    stat_o                       = '0;
    stat_o[B_HELD]               = held_q;
    stat_o[B_UNC]                = unc_q;
    stat_o[B_REFR]               = refr_q;
    stat_o[B_PAR]                = par_q;
    stat_o[B_ENA]                = !dis_q;
    stat_o[B_SYNLO +: SYN_W]     = syn_q;
    stat_o[B_PWR]                = pwr_q;
    stat_o[ADDR_W-1:0]           = addr_q;
  end

  assign force_chk_o = frc_q;
  assign ecc_dis_o   = dis_q;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [SYN_W-1:0]  evt_syn_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic              evt_uncorr_i,
  input  logic              evt_refresh_i,
  input  logic              evt_parity_i,
  input  logic              pwr_low_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [POS_W-1:0]  fail_pos_o,
  output logic              fail_in_check_o,
  output logic              correctable_o,
  output logic              uncorrectable_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [CHK_W:0]    force_chk_o,
  output logic              force_en_o,
  output logic              ecc_dis_o
);
  dec_res_t dec;
  logic     cap;

  ecc_synd_dec u_dec (
    .vld_i (evt_valid_i),
    .syn_i (evt_syn_i),
    .res_o (dec)
  );

  assign cap = evt_valid_i && ((evt_syn_i != '0) || evt_uncorr_i);

  ecc_stat_reg #(.ADDR_W(ADDR_W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .cap_syn_i   (evt_syn_i),
    .cap_addr_i  (evt_addr_i),
    .cap_unc_i   (evt_uncorr_i || dec.uncorr),
    .refr_set_i  (evt_valid_i && evt_refresh_i),
    .par_set_i   (evt_valid_i && evt_parity_i),
    .pwr_set_i   (pwr_low_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .stat_o      (stat_o),
    .force_chk_o (force_chk_o),
    .ecc_dis_o   (ecc_dis_o)
  );

  assign fail_pos_o      = dec.pos;
  assign fail_in_check_o = dec.in_chk;
  assign correctable_o   = dec.corr;
  assign uncorrectable_o = dec.uncorr;
  assign force_en_o      = |force_chk_o;
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk
  import ecc_cap_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic [SYN_W-1:0]  evt_syn_i,
  input logic              evt_refresh_i,
  input logic              wr_en_i,
  input logic [STAT_W-1:0] wr_data_i,
  input logic              fail_in_check_o,
  input logic              correctable_o,
  input logic              uncorrectable_o,
  input logic [STAT_W-1:0] stat_o,
  input logic [CHK_W:0]    force_chk_o,
  input logic              ecc_dis_o
);
  a_r4_class_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(correctable_o && uncorrectable_o));

  a_r1_zero_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_syn_i == '0) |-> !correctable_o && !uncorrectable_o);

  a_r2_chk_corr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_in_check_o |-> correctable_o && evt_syn_i[SYN_W-1]);

  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_syn_i != '0 && !stat_o[B_HELD]) |=>
      stat_o[B_HELD] && stat_o[B_SYNLO +: SYN_W] == $past(evt_syn_i));

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[B_HELD] && !(wr_en_i && wr_data_i[B_HELD])) |=>
      stat_o[B_HELD] && $stable(stat_o[B_UNC]) &&
      $stable(stat_o[B_SYNLO +: SYN_W]) && $stable(stat_o[21:0]));

  a_r8_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_refresh_i) |=> stat_o[B_REFR]);

  a_r10_wr_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ecc_dis_o == $past(wr_data_i[B_DIS]) &&
                force_chk_o == $past(wr_data_i[B_FRCLO +: CHK_W+1]));
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .evt_valid_i     (evt_valid_i),
  .evt_syn_i       (evt_syn_i),
  .evt_refresh_i   (evt_refresh_i),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .fail_in_check_o (fail_in_check_o),
  .correctable_o   (correctable_o),
  .uncorrectable_o (uncorrectable_o),
  .stat_o          (stat_o),
  .force_chk_o     (force_chk_o),
  .ecc_dis_o       (ecc_dis_o)
);

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb_top;
  logic        clk = 0, rst_ni = 0;
  logic        evt_valid, evt_unc, evt_ref, evt_par, pwr_low, wr_en;
  logic [6:0]  evt_syn;
  logic [21:0] evt_addr;
  logic [35:0] wr_data;
  logic [5:0]  fail_pos;
  logic        fail_chk, corr, unc;
  logic [35:0] stat;
  logic [6:0]  force_chk;
  logic        force_en, ecc_dis;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_err_capture dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .evt_valid_i(evt_valid), .evt_syn_i(evt_syn),
    .evt_addr_i(evt_addr), .evt_uncorr_i(evt_unc), .evt_refresh_i(evt_ref),
    .evt_parity_i(evt_par), .pwr_low_i(pwr_low), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fail_pos_o(fail_pos), .fail_in_check_o(fail_chk), .correctable_o(corr),
    .uncorrectable_o(unc), .stat_o(stat), .force_chk_o(force_chk),
    .force_en_o(force_en), .ecc_dis_o(ecc_dis)
  );

  // syndrome, corr, uncorr, in_check, position
  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    {7'o000, 1'b0, 1'b0, 1'b0, 6'd0},   // R1
    {7'o101, 1'b1, 1'b0, 1'b1, 6'd0},   // R2
    {7'o102, 1'b1, 1'b0, 1'b1, 6'd1},
    {7'o104, 1'b1, 1'b0, 1'b1, 6'd2},
    {7'o110, 1'b1, 1'b0, 1'b1, 6'd3},
    {7'o120, 1'b1, 1'b0, 1'b1, 6'd4},
    {7'o140, 1'b1, 1'b0, 1'b1, 6'd5},
    {7'o100, 1'b1, 1'b0, 1'b1, 6'd6},
    {7'o111, 1'b1, 1'b0, 1'b0, 6'd35},  // R3
    {7'o116, 1'b1, 1'b0, 1'b0, 6'd30},
    {7'o121, 1'b1, 1'b0, 1'b0, 6'd29},
    {7'o136, 1'b1, 1'b0, 1'b0, 6'd18},
    {7'o141, 1'b1, 1'b0, 1'b0, 6'd17},
    {7'o155, 1'b1, 1'b0, 1'b0, 6'd7},
    {7'o166, 1'b1, 1'b0, 1'b0, 6'd0},
    {7'o011, 1'b0, 1'b1, 1'b0, 6'd0},   // R4
    {7'o117, 1'b0, 1'b1, 1'b0, 6'd0},
    {7'o107, 1'b0, 1'b1, 1'b0, 6'd0},
    {7'o170, 1'b0, 1'b1, 1'b0, 6'd0},
    {7'o003, 1'b0, 1'b1, 1'b0, 6'd0}
  };

  logic e_held, e_unc, e_ref, e_par, e_en, e_pwr;
  logic [6:0]  e_syn;
  logic [21:0] e_addr;

  function automatic logic [35:0] exp_stat();
    return {e_held, e_unc, e_ref, e_par, e_en, e_syn, e_pwr, 1'b0, e_addr};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_valid = 0; evt_syn = 0; evt_addr = 0; evt_unc = 0; evt_ref = 0;
    evt_par = 0; pwr_low = 0; wr_en = 0; wr_data = 0;
  endtask

  // one clock of stimulus, applied at a falling edge, removed at the next
  task automatic step(logic ev, logic [6:0] s, logic [21:0] a, logic u, logic rf,
                      logic pa, logic pw, logic we, logic [35:0] wd);
    @(negedge clk);
    evt_valid = ev; evt_syn = s; evt_addr = a; evt_unc = u; evt_ref = rf;
    evt_par = pa; pwr_low = pw; wr_en = we; wr_data = wd;
    @(negedge clk);
    idle();
    #1;
  endtask

  function automatic logic [35:0] bit36(int b);
    return 36'(1) << b;
  endfunction

  initial begin
    idle();
    e_held = 0; e_unc = 0; e_ref = 0; e_par = 0; e_en = 1; e_pwr = 0;
    e_syn = 0; e_addr = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;

    // decoder table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evt_valid = 1; evt_syn = VEC[i][15:9];
      #2;
      check($sformatf("R1/R2/R3/R4 decode syn=%o", VEC[i][15:9]),
            64'({corr, unc, fail_chk, fail_pos}), 64'(VEC[i][8:0]));
    end
    @(negedge clk);
    idle();
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    #1;
    check("R11 reset status", 64'(stat), 64'(bit36(31)));
    check("R11 reset controls", 64'({force_chk, force_en, ecc_dis}), 64'(0));

    step(1, 7'o121, 22'h12345, 0, 0, 0, 0, 0, 0);
    e_held = 1; e_syn = 7'o121; e_addr = 22'h12345;
    check("R5 capture", 64'(stat), 64'(exp_stat()));

    step(1, 7'o011, 22'h3ABCD, 1, 0, 0, 0, 0, 0);
    check("R6 held record frozen", 64'(stat), 64'(exp_stat()));

    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R7 write of 0 to held bit ignored", 64'(stat), 64'(exp_stat()));

    step(0, 0, 0, 0, 0, 0, 0, 1, bit36(35));
    e_held = 0;
    check("R7 held W1C", 64'(stat), 64'(exp_stat()));

    step(1, 7'o000, 22'h000FF, 1, 0, 0, 0, 0, 0);
    e_held = 1; e_unc = 1; e_syn = 0; e_addr = 22'h000FF;
    check("R4 uncorrectable flag capture", 64'(stat), 64'(exp_stat()));

    step(0, 0, 0, 0, 0, 0, 0, 1, bit36(34));
    check("R4 bit 34 read-only", 64'(stat), 64'(exp_stat()));

    step(1, 7'o166, 22'h01111, 0, 0, 0, 0, 1, bit36(35));
    e_unc = 0; e_syn = 7'o166; e_addr = 22'h01111;
    check("R7 clear with same-cycle capture", 64'(stat), 64'(exp_stat()));

    step(1, 7'o000, 0, 0, 1, 0, 0, 0, 0);
    e_ref = 1;
    check("R8 refresh set", 64'(stat), 64'(exp_stat()));
    step(1, 7'o000, 0, 0, 1, 0, 0, 1, bit36(33));
    check("R8 refresh set wins over clear", 64'(stat), 64'(exp_stat()));
    step(0, 0, 0, 0, 0, 0, 0, 1, bit36(33));
    e_ref = 0;
    check("R8 refresh W1C", 64'(stat), 64'(exp_stat()));

    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    e_pwr = 1;
    check("R8 power low set", 64'(stat), 64'(exp_stat()));
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 power low sticky", 64'(stat), 64'(exp_stat()));
    step(0, 0, 0, 0, 0, 0, 0, 1, bit36(23));
    e_pwr = 0;
    check("R8 power low W1C", 64'(stat), 64'(exp_stat()));

    step(0, 0, 0, 0, 0, 0, 0, 1, bit36(32));
    e_par = 1;
    check("R9 parity write 1", 64'(stat), 64'(exp_stat()));
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    e_par = 0;
    check("R9 parity write 0", 64'(stat), 64'(exp_stat()));
    step(1, 0, 0, 0, 0, 1, 0, 1, 0);
    e_par = 1;
    check("R9 parity event wins", 64'(stat), 64'(exp_stat()));

    step(0, 0, 0, 0, 0, 0, 0, 1, 36'({7'h55, 1'b1}));
    e_par = 0; e_en = 0;
    check("R10 force/disable", 64'({force_chk, force_en, ecc_dis}), 64'({7'h55, 1'b1, 1'b1}));
    check("R10 enable bit clear", 64'(stat), 64'(exp_stat()));
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    e_en = 1;
    check("R10 controls released", 64'({force_chk, force_en, ecc_dis, stat[31]}), 64'(4'b0001));

    step(0, 0, 0, 0, 0, 0, 0, 1, bit36(35));
    e_held = 0;
    @(negedge clk);
    evt_valid = 1; evt_syn = 7'o117; evt_addr = 22'h3FFFFF;
    #2;
    check("R4 unmapped code classified", 64'({corr, unc}), 64'(2'b01));
    @(negedge clk);
    idle();
    #1;
    e_held = 1; e_unc = 1; e_syn = 7'o117; e_addr = 22'h3FFFFF;
    check("R4 unmapped code capture", 64'(stat), 64'(exp_stat()));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule